// File: doc/BRIEF.md
# Clock Output Power Management Controller

This controller sits beside the output stage of a clock generator with six outputs (four routed outputs A to D, a fixed output E taken from the first PLL, and a buffered copy of the reference) and three PLLs. It turns two asynchronous control pins and a set of configuration bits into three groups of outputs. The first group is one enable per output pin, used to tristate that pin. The second is a power-down per PLL, plus one power-down for the dividers and one for the reference oscillator. The third is a flag that shows that at least one PLL is waiting to relock.

The enable pin works in one of two ways. In the first, taking it low only tristates the outputs. In the second, when full shutdown is configured, it also powers down the PLLs, the dividers and the oscillator. The suspend pin works in one of two ways as well. When suspend is configured, a low level turns off a masked set of outputs and a masked set of PLLs. Otherwise the pin is handed on, synchronized, as bit 2 of the frequency select. Any output whose current source is a PLL that is off stays disabled, and it also stays disabled after that PLL restarts, until a programmable lock wait has run out. Both pins pass through two flops before they have any effect. All interfaces are plain level signals, so the block has no flow control.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: While the synchronized enable pin is low, all six bits of `out_en` are 0, whatever else is configured.
- R2: With `cfg_shdn_en`=1 and the synchronized enable pin low, `pll_pd`=3'b111, `cnt_pd`=1 and `osc_pd`=1. With `cfg_shdn_en`=0, the enable pin never sets `pll_pd`, `cnt_pd` or `osc_pd`.
- R3: With `cfg_sus_en`=1 and the synchronized suspend pin low, every output j with `cfg_sus_out[j]`=1 is disabled and every PLL k with `cfg_sus_pll[k]`=1 is powered down. Output bits are 0=A, 1=B, 2=C, 3=D, 4=E, 5=reference buffer. PLL bits are 0=PLL1, 1=PLL2, 2=PLL3.
- R4: An output whose source PLL is powered down or still waiting to lock is disabled. `route_sel[2j+1:2j]` picks the source of output j (j=0..3): 0=reference, 1=PLL1, 2=PLL2, 3=PLL3. Output E always takes PLL1, and the reference buffer always takes the reference.
- R5: An output-only suspend (`cfg_sus_pll`=0) powers down no PLL and leaves the unmasked outputs enabled.
- R6: With `cfg_sus_en`=0 the suspend pin has no effect on power, and `fsel2` follows the synchronized pin. With `cfg_sus_en`=1, `fsel2` is 0.
- R7: When a PLL's power-down is released, that PLL counts as waiting for exactly `cfg_lock_wait` cycles. While any PLL waits, `relock_pending` is 1. A wait of 0 gives no waiting cycles.
- R8: A change on either pin reaches the outputs after the second rising clock edge that follows it, and not before.
- R9: During reset and right after it, `out_en`=0 and `relock_pending`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oe_pin | input | 1 | Asynchronous enable / shutdown pin, active high |
| sus_pin | input | 1 | Asynchronous suspend / select-bit-2 pin |
| cfg_shdn_en | input | 1 | 1: enable pin low means full shutdown |
| cfg_sus_en | input | 1 | 1: suspend pin acts as suspend |
| cfg_sus_out | input | 6 | Outputs turned off by suspend |
| cfg_sus_pll | input | 3 | PLLs powered down by suspend |
| route_sel | input | 8 | Source codes of outputs A to D, 2 bits each |
| cfg_lock_wait | input | LOCK_W | Lock wait in clock cycles |
| out_en | output | 6 | Per-output enable, 0 = tristate |
| pll_pd | output | 3 | Per-PLL power-down |
| cnt_pd | output | 1 | Divider power-down |
| osc_pd | output | 1 | Reference oscillator power-down |
| relock_pending | output | 1 | At least one PLL is waiting to lock |
| fsel2 | output | 1 | Synchronized frequency select bit 2 |

## Verification
A suspend that masks a PLL can line up with the end of a shutdown. In the same cycle, one PLL can then be entering its lock wait while another is forced off, and an output routed to either one must stay disabled. The bench provokes this overlap by toggling both pins at random, with the routing, the masks and the lock wait changed every so often. A cycle-level model built from the requirements judges every output on every cycle. Directed cases pin down the exact edge of the synchronizer delay and the length of the lock wait.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;
  localparam int NUM_OUT = 6;
  localparam int NUM_PLL = 3;
  localparam int NUM_XP  = 4;
  localparam int SRC_W   = 2;
  localparam int OUT_E   = 4;

  typedef enum logic [SRC_W-1:0] {
    SRC_REF  = 2'd0,
    SRC_PLL1 = 2'd1,
    SRC_PLL2 = 2'd2,
    SRC_PLL3 = 2'd3
  } src_e;

  function automatic logic src_is_off(src_e s, logic [NUM_PLL-1:0] off);
    case (s)
      SRC_PLL1: return off[0];
      SRC_PLL2: return off[1];
      SRC_PLL3: return off[2];
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      d_out  <= RST_VAL;
    end else begin
      stage1 <= d_in;
      d_out  <= stage1;
    end
  end
endmodule

// File: rtl/pm_lock_timer.sv
module pm_lock_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd,
  input  logic [CW-1:0] wait_cfg,
  output logic          waiting
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (pd)         cnt <= wait_cfg;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign waiting = !pd && (cnt != '0);

  AST_WAIT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pd) && ($past(wait_cfg) != '0)) |-> waiting); // R7
  AST_WAIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !pd) |=> (pd || waiting || $past(cnt) == 1)); // R7
endmodule

// File: rtl/pm_out_gate.sv
module pm_out_gate
  import clkpm_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      oe_on,
  input  logic [NUM_OUT-1:0]        out_sus,
  input  logic [NUM_PLL-1:0]        pll_off,
  input  logic [NUM_XP*SRC_W-1:0]   route_sel,
  output logic [NUM_OUT-1:0]        out_en
);
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    src_e src;
    logic blocked;
    if (j < NUM_XP) begin : g_xp
      assign src = src_e'(route_sel[j*SRC_W +: SRC_W]);
    end else if (j == OUT_E) begin : g_e
      assign src = SRC_PLL1;
    end else begin : g_ref
      assign src = SRC_REF;
    end
    assign blocked   = src_is_off(src, pll_off);
    assign out_en[j] = oe_on && !out_sus[j] && !blocked;

    AST_DEP_PLL1_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_PLL1 && pll_off[0]) |-> !out_en[j]); // R4
    AST_SUS_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      out_sus[j] |-> !out_en[j]); // R3
  end
endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
  import clkpm_pkg::*;
#(
  parameter int LOCK_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     oe_pin,
  input  logic                     sus_pin,
  input  logic                     cfg_shdn_en,
  input  logic                     cfg_sus_en,
  input  logic [NUM_OUT-1:0]       cfg_sus_out,
  input  logic [NUM_PLL-1:0]       cfg_sus_pll,
  input  logic [NUM_XP*SRC_W-1:0]  route_sel,
  input  logic [LOCK_W-1:0]        cfg_lock_wait,
  output logic [NUM_OUT-1:0]       out_en,
  output logic [NUM_PLL-1:0]       pll_pd,
  output logic                     cnt_pd,
  output logic                     osc_pd,
  output logic                     relock_pending,
  output logic                     fsel2
);
  logic oe_s, sus_s;
  logic shutdown, sus_act;
  logic [NUM_PLL-1:0] pll_wait;
  logic [NUM_OUT-1:0] out_sus;

  pm_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({oe_pin, sus_pin}),
    .d_out ({oe_s, sus_s})
  );

  assign shutdown = cfg_shdn_en && !oe_s;
  assign sus_act  = cfg_sus_en && !sus_s;
  assign out_sus  = sus_act ? cfg_sus_out : '0;

  for (genvar k = 0; k < NUM_PLL; k++) begin : g_pll
    assign pll_pd[k] = shutdown || (sus_act && cfg_sus_pll[k]);
    pm_lock_timer #(.CW(LOCK_W)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .pd       (pll_pd[k]),
      .wait_cfg (cfg_lock_wait),
      .waiting  (pll_wait[k])
    );
  end

  pm_out_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .oe_on     (oe_s),
    .out_sus   (out_sus),
    .pll_off   (pll_pd | pll_wait),
    .route_sel (route_sel),
    .out_en    (out_en)
  );

  assign cnt_pd         = shutdown;
  assign osc_pd         = shutdown;
  assign relock_pending = |pll_wait;
  assign fsel2          = cfg_sus_en ? 1'b0 : sus_s;

  AST_OE_GATES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(oe_pin, 2) |-> (out_en == '0)); // R1
  AST_SHDN_ALL_PD: assert property (@(posedge clk) disable iff (!rst_n)
    osc_pd |-> ((&pll_pd) && cnt_pd)); // R2
  AST_NO_EARLY_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en != '0) |-> $past(oe_pin, 2)); // R8
  AST_SUS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sus_en && !$past(sus_pin, 2)) |-> ((out_en & cfg_sus_out) == '0)); // R3
  AST_RELOCK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    relock_pending |-> !osc_pd); // R7
endmodule

// File: tb/sim_clk_pwr_ctrl.sv
module sim_clk_pwr_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic oe_pin = 1'b0, sus_pin = 1'b1;
  logic cfg_shdn_en = 1'b0, cfg_sus_en = 1'b0;
  logic [5:0] cfg_sus_out = '0;
  logic [2:0] cfg_sus_pll = '0;
  logic [7:0] route_sel = '0;
  logic [15:0] cfg_lock_wait = '0;
  logic [5:0] out_en;
  logic [2:0] pll_pd;
  logic cnt_pd, osc_pd, relock_pending, fsel2;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clk_pwr_ctrl u0 (.*);

  // reference model from the requirements
  logic m_o1, m_o2, m_s1, m_s2;
  logic [15:0] m_cnt [3];

  function automatic logic [2:0] exp_pd();
    logic shut, sa;
    logic [2:0] r;
    shut = cfg_shdn_en && !m_o2;
    sa = cfg_sus_en && !m_s2;
    for (int k = 0; k < 3; k++) r[k] = shut || (sa && cfg_sus_pll[k]);
    return r;
  endfunction

  function automatic logic [2:0] exp_wait();
    logic [2:0] pd, r;
    pd = exp_pd();
    for (int k = 0; k < 3; k++) r[k] = !pd[k] && (m_cnt[k] != 0);
    return r;
  endfunction

  function automatic logic [5:0] exp_en();
    logic [2:0] off;
    logic [5:0] r;
    logic sa;
    int src;
    off = exp_pd() | exp_wait();
    sa = cfg_sus_en && !m_s2;
    for (int j = 0; j < 6; j++) begin
      if (j < 4) src = int'(route_sel[2*j +: 2]);
      else if (j == 4) src = 1;
      else src = 0;
      r[j] = m_o2 && !(sa && cfg_sus_out[j]);
      if (src != 0 && off[src-1]) r[j] = 1'b0;
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_o1 <= 0; m_o2 <= 0; m_s1 <= 1; m_s2 <= 1;
      for (int k = 0; k < 3; k++) m_cnt[k] <= '0;
    end else begin
      logic [2:0] pd;
      pd = exp_pd();
      for (int k = 0; k < 3; k++)
        if (pd[k]) m_cnt[k] <= cfg_lock_wait;
        else if (m_cnt[k] != 0) m_cnt[k] <= m_cnt[k] - 1;
      m_o2 <= m_o1; m_o1 <= oe_pin;
      m_s2 <= m_s1; m_s1 <= sus_pin;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R4 out_en", 16'(out_en), 16'(exp_en()));
    chk("R3 pll_pd", 16'(pll_pd), 16'(exp_pd()));
    chk("R2 osc_pd", 16'(osc_pd), 16'(cfg_shdn_en && !m_o2));
    chk("R2 cnt_pd", 16'(cnt_pd), 16'(cfg_shdn_en && !m_o2));
    chk("R7 relock", 16'(relock_pending), 16'(|exp_wait()));
    chk("R6 fsel2", 16'(fsel2), 16'(cfg_sus_en ? 1'b0 : m_s2));
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt_hi;
    void'($urandom(32'h0C1A_5EED));
    route_sel = 8'h55;
    step(2);
    chk("R9 out_en in reset", 16'(out_en), 16'h0);
    chk("R9 relock in reset", 16'(relock_pending), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 out_en after reset", 16'(out_en), 16'h0);
    chk("R9 relock after reset", 16'(relock_pending), 16'h0);

    // R8: exact synchronizer delay, OE-only mode
    oe_pin = 1'b1; step(4);
    chk("R8 outputs on", 16'(out_en), 16'h3F);
    oe_pin = 1'b0; step(1);
    chk("R8 one edge later still on", 16'(out_en), 16'h3F);
    step(1);
    chk("R1 two edges later all off", 16'(out_en), 16'h0);
    chk("R2 OE-only keeps PLLs", 16'(pll_pd), 16'h0);
    chk("R2 OE-only keeps osc", 16'(osc_pd), 16'h0);

    // R2 / R7: full shutdown then relock wait of 4
    cfg_shdn_en = 1'b1; cfg_lock_wait = 16'd4; step(3);
    chk("R2 shutdown pll_pd", 16'(pll_pd), 16'h7);
    chk("R2 shutdown osc", 16'(osc_pd), 16'h1);
    chk("R2 shutdown cnt", 16'(cnt_pd), 16'h1);
    oe_pin = 1'b1; step(2);
    chk("R7 ref only during wait", 16'(out_en), 16'h20);
    cnt_hi = 0;
    for (int i = 0; i < 10; i++) begin
      if (relock_pending) cnt_hi++;
      step(1);
    end
    chk("R7 wait length", 16'(cnt_hi), 16'd4);
    chk("R7 outputs after wait", 16'(out_en), 16'h3F);

    // R5: output-only suspend
    cfg_shdn_en = 1'b0; cfg_lock_wait = 16'd0;
    cfg_sus_en = 1'b1; cfg_sus_out = 6'b000011; cfg_sus_pll = 3'b000;
    sus_pin = 1'b0; step(3);
    chk("R5 no PLL down", 16'(pll_pd), 16'h0);
    chk("R5 masked outputs", 16'(out_en), 16'h3C);
    chk("R6 fsel2 zero in suspend", 16'(fsel2), 16'h0);

    // R3 / R4: PLL2 suspended, output A routed to it
    cfg_sus_out = '0; cfg_sus_pll = 3'b010; route_sel = 8'h02; step(1);
    chk("R3 PLL2 down", 16'(pll_pd), 16'h2);
    chk("R4 A follows PLL2", 16'(out_en), 16'h3E);
    sus_pin = 1'b1; step(3);

    // R6: suspend not configured
    cfg_sus_en = 1'b0; sus_pin = 1'b0; step(1);
    chk("R6 fsel2 before sync", 16'(fsel2), 16'h1);
    step(1);
    chk("R6 fsel2 follows", 16'(fsel2), 16'h0);
    chk("R6 no power effect", 16'(pll_pd), 16'h0);
    chk("R6 outputs unaffected", 16'(out_en), 16'h3F);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      cmp_model();
      if ($urandom_range(15) == 0) oe_pin = ~oe_pin;
      if ($urandom_range(7) == 0) sus_pin = ~sus_pin;
      if ($urandom_range(63) == 0) begin
        cfg_shdn_en   = 1'($urandom);
        cfg_sus_en    = 1'($urandom);
        cfg_sus_out   = 6'($urandom);
        cfg_sus_pll   = 3'($urandom);
        route_sel     = 8'($urandom);
        cfg_lock_wait = 16'($urandom_range(6));
      end
      step(1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule